// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits beside the instruction sequencer of an 8-bit processor that has a 16-bit address space. The sequencer fetches an opcode, leaves the program counter pointing at the first operand byte, and pulses `start` with the operand mode and the current X and Y index values. The unit then fetches the operand bytes and advances the program counter past them. It follows whatever pointer chain the mode calls for through a byte-wide synchronous read port and returns a 16-bit effective pointer together with the byte stored at that pointer. A one-cycle `done` strobe marks the result.

A raw request (`raw` high) is used when listing code rather than running it. The unit still consumes the operand bytes, but it returns the operand as written: it adds no index register and follows no pointer. Index arithmetic is always a full 16-bit sum, so zero-page forms can reach past page zero. Relative targets are measured from the program counter after the offset byte has been fetched.

Top module: `ea_gen`

Mode codes on `mode`: 0 accumulator, 1 implied, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 indirect, 10 (zero page+X) indirect, 11 (zero page) indirect+Y, 12 relative. Codes 13 to 15 are invalid.

## Requirements
- R1: After reset the program counter reads 0x0600, and `done`, `err`, `busy` and `mem_rd` are low.
- R2: Modes 0 and 1 read no memory, leave the program counter unchanged and return pointer 0x0000 and value 0x00.
- R3: Modes 2 and 3 read one byte B at the program counter, advance it by one, and return pointer {0x00,B} and value B.
- R4: Mode 6 reads the low byte and then the high byte of an address W from PC and PC+1, advances the PC by two, and returns pointer W and value mem[W].
- R5: Mode 12 reads a byte at PC and treats it as a signed offset. The target is (PC+1)+offset, taken modulo 2^16. The unit returns the target and mem[target].
- R6: Mode 9 reads a 16-bit operand P (low byte first), then builds the pointer from mem[P] (low) and mem[P+1] (high) and returns it with the byte it addresses.
- R7: Modes 7 and 8 add X or Y, zero-extended, to the 16-bit operand with a 16-bit sum, and return that address and its byte.
- R8: Modes 4 and 5 add X or Y to the operand byte with a 16-bit sum, with no wrap inside page zero (0xF8+0x10 gives 0x0108).
- R9: Mode 10 forms A=Z+X as a 16-bit sum and builds the pointer from mem[A] (low) and mem[A+1] (high).
- R10: Mode 11 builds a base from mem[Z] (low) and mem[Z+1] (high), where Z+1 is a 16-bit sum so Z=0xFF reads 0x0100, then adds Y.
- R11: With `raw` high, every mode except 0 and 1 returns the operand as fetched (the zero-extended byte, the 16-bit word, or the relative target). The returned value is its low byte, no index is added, and no memory read follows the operand bytes.
- R12: A start with mode 13, 14 or 15 raises `err` for exactly one cycle, reads no memory, leaves the PC unchanged and gives no `done`.
- R13: `done` is high for exactly one cycle per accepted request. Memory reads per request are: modes 0-1 none, 2-3 one, 4-5 and 12 two, 6-8 three, 10-11 four, and 9 five. In raw mode the count drops to the number of operand bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode | input | 4 | Operand mode code |
| raw | input | 1 | Return the operand without index or pointer resolution |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| mem_rd | output | 1 | Read enable of the byte port |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pc | output | 16 | Program counter |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | One-cycle strobe for an invalid mode |
| ea_ptr | output | 16 | Effective pointer |
| ea_val | output | 8 | Byte at the effective pointer |

## Verification
Each mode is started from a program counter that keeps advancing across requests, so any miscount of operand bytes shows up in every later result. The operands are chosen to sit on boundaries. A zero-page base of 0xF8 plus 0x10 separates a 16-bit sum from a page-zero wrap. A pointer at 0xFF separates a 16-bit Z+1 from a wrapped one, and 0x0FFF+0xFF shows that the carry reaches the high byte. Offsets 0x10 and 0xF0 separate signed from unsigned relative offsets and show whether the base is taken before or after the fetch. The count of read cycles per request separates raw mode from real dereferencing even where the two give the same pointer.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        M_ACCUM  = 4'd0,
        M_IMPL   = 4'd1,
        M_IMM    = 4'd2,
        M_ZPG    = 4'd3,
        M_ZPG_X  = 4'd4,
        M_ZPG_Y  = 4'd5,
        M_ABS    = 4'd6,
        M_ABS_X  = 4'd7,
        M_ABS_Y  = 4'd8,
        M_IND    = 4'd9,
        M_ZX_IND = 4'd10,
        M_ZIND_Y = 4'd11,
        M_REL    = 4'd12
    } am_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP0,
        ST_B1,
        ST_B2,
        ST_PL,
        ST_PH,
        ST_DAT
    } st_e;

    localparam logic [3:0] LAST_MODE = 4'd12;

    function automatic logic mode_ok(logic [3:0] m);
        return m <= LAST_MODE;
    endfunction

    function automatic logic no_operand(logic [3:0] m);
        return (m == M_ACCUM) || (m == M_IMPL);
    endfunction

    function automatic logic two_byte(am_e m);
        return (m == M_ABS) || (m == M_ABS_X) || (m == M_ABS_Y) || (m == M_IND);
    endfunction

    function automatic logic uses_y(am_e m);
        return (m == M_ZPG_Y) || (m == M_ABS_Y) || (m == M_ZIND_Y);
    endfunction

endpackage

// File: rtl/ea_add.sv
module ea_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    assign s = a + b;
endmodule

// File: rtl/ea_pc.sv
module ea_pc #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] PC_INIT = 16'h0600
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)
            pc <= PC_INIT;
        else if (inc)
            pc <= pc + AW'(1);
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            DW      = 8,
    parameter logic [AW-1:0] PC_INIT = 16'h0600
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic          raw,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] ea_ptr,
    output logic [DW-1:0] ea_val
);
    localparam int NADD = 3;
    localparam int L_IDX = 0;
    localparam int L_REL = 1;
    localparam int L_NXT = 2;
    localparam int PAD = AW - DW;

    st_e           st_q, st_d;
    am_e           md_q;
    logic          raw_q;
    logic [DW-1:0] x_q, y_q, lo_q;
    logic [AW-1:0] pa_q, ea_q;

    logic          pc_inc, fin, ld_lo, ld_pa, ld_ea;
    logic [AW-1:0] fin_ptr;
    logic [DW-1:0] fin_val;
    logic [AW-1:0] b_ext, word;
    logic [DW-1:0] idx_sel;

    logic [NADD-1:0][AW-1:0] add_a, add_b, add_s;

    ea_pc #(.AW(AW), .PC_INIT(PC_INIT)) u_pc (
        .clk (clk),
        .rst (rst),
        .inc (pc_inc),
        .pc  (pc)
    );

    assign b_ext   = {{PAD{1'b0}}, mem_rdata};
    assign word    = {mem_rdata, lo_q};
    assign idx_sel = uses_y(md_q) ? y_q : x_q;

    // lane 0: index sum, lane 1: relative target, lane 2: pointer high byte address
    assign add_a[L_IDX] = (st_q == ST_B1) ? b_ext : word;
    assign add_b[L_IDX] = {{PAD{1'b0}}, idx_sel};
    assign add_a[L_REL] = pc;
    assign add_b[L_REL] = {{PAD{mem_rdata[DW-1]}}, mem_rdata};
    assign add_a[L_NXT] = pa_q;
    assign add_b[L_NXT] = AW'(1);

    for (genvar g = 0; g < NADD; g++) begin : g_add
        ea_add #(.W(AW)) u_add (
            .a (add_a[g]),
            .b (add_b[g]),
            .s (add_s[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        mem_rd   = 1'b0;
        mem_addr = pc;
        pc_inc   = 1'b0;
        fin      = 1'b0;
        fin_ptr  = '0;
        fin_val  = '0;
        ld_lo    = 1'b0;
        ld_pa    = 1'b0;
        ld_ea    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start && mode_ok(mode)) begin
                    if (no_operand(mode))
                        fin = 1'b1;
                    else
                        st_d = ST_OP0;
                end
            end
            ST_OP0: begin
                mem_rd = 1'b1;
                pc_inc = 1'b1;
                st_d   = ST_B1;
            end
            ST_B1: begin
                if (two_byte(md_q)) begin
                    mem_rd = 1'b1;
                    pc_inc = 1'b1;
                    ld_lo  = 1'b1;
                    st_d   = ST_B2;
                end else if (md_q == M_REL) begin
                    if (raw_q) begin
                        fin     = 1'b1;
                        fin_ptr = add_s[L_REL];
                        fin_val = add_s[L_REL][DW-1:0];
                    end else begin
                        mem_rd   = 1'b1;
                        mem_addr = add_s[L_REL];
                        ld_ea    = 1'b1;
                        st_d     = ST_DAT;
                    end
                end else if (raw_q || md_q == M_IMM || md_q == M_ZPG) begin
                    fin     = 1'b1;
                    fin_ptr = b_ext;
                    fin_val = mem_rdata;
                end else begin
                    mem_rd = 1'b1;
                    unique case (md_q)
                        M_ZPG_X, M_ZPG_Y: begin
                            mem_addr = add_s[L_IDX];
                            ld_ea    = 1'b1;
                            st_d     = ST_DAT;
                        end
                        M_ZX_IND: begin
                            mem_addr = add_s[L_IDX];
                            ld_pa    = 1'b1;
                            st_d     = ST_PL;
                        end
                        default: begin
                            mem_addr = b_ext;
                            ld_pa    = 1'b1;
                            st_d     = ST_PL;
                        end
                    endcase
                end
            end
            ST_B2: begin
                if (raw_q) begin
                    fin     = 1'b1;
                    fin_ptr = word;
                    fin_val = lo_q;
                end else begin
                    mem_rd = 1'b1;
                    if (md_q == M_IND) begin
                        mem_addr = word;
                        ld_pa    = 1'b1;
                        st_d     = ST_PL;
                    end else begin
                        mem_addr = (md_q == M_ABS) ? word : add_s[L_IDX];
                        ld_ea    = 1'b1;
                        st_d     = ST_DAT;
                    end
                end
            end
            ST_PL: begin
                mem_rd   = 1'b1;
                mem_addr = add_s[L_NXT];
                ld_lo    = 1'b1;
                st_d     = ST_PH;
            end
            ST_PH: begin
                mem_rd   = 1'b1;
                mem_addr = (md_q == M_ZIND_Y) ? add_s[L_IDX] : word;
                ld_ea    = 1'b1;
                st_d     = ST_DAT;
            end
            ST_DAT: begin
                fin     = 1'b1;
                fin_ptr = ea_q;
                fin_val = mem_rdata;
            end
            default: st_d = ST_IDLE;
        endcase
        if (fin)
            st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            md_q   <= M_ACCUM;
            raw_q  <= 1'b0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            pa_q   <= '0;
            ea_q   <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            ea_ptr <= '0;
            ea_val <= '0;
        end else begin
            st_q <= st_d;
            done <= fin;
            err  <= (st_q == ST_IDLE) && start && !mode_ok(mode);
            if (st_q == ST_IDLE && start) begin
                md_q  <= am_e'(mode);
                raw_q <= raw;
                x_q   <= x_idx;
                y_q   <= y_idx;
            end
            if (ld_lo) lo_q <= mem_rdata;
            if (ld_pa) pa_q <= mem_addr;
            if (ld_ea) ea_q <= mem_addr;
            if (fin) begin
                ea_ptr <= fin_ptr;
                ea_val <= fin_val;
            end
        end
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_rd,
    input logic [AW-1:0] pc,
    input logic          busy,
    input logic          done,
    input logic          err
);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_err_no_done_R12: assert property (@(posedge clk) disable iff (rst)
        err |-> !done);

    assert_err_pc_hold_R12: assert property (@(posedge clk) disable iff (rst)
        err |-> (pc == $past(pc)));

    assert_pc_step_R13: assert property (@(posedge clk) disable iff (rst)
        (pc != $past(pc)) |-> ((pc == $past(pc) + AW'(1)) && $past(mem_rd)));

    assert_idle_noread_R13: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mem_rd (mem_rd),
    .pc     (pc),
    .busy   (busy),
    .done   (done),
    .err    (err)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        raw = 1'b0;
    logic [7:0]  x_idx = '0, y_idx = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] pc;
    logic        busy, done, err;
    logic [15:0] ea_ptr;
    logic [7:0]  ea_val;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [15:0] exp_pc = 16'h0600;
    logic [7:0] mem [0:4095];

    always #2.5 clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .raw(raw),
        .x_idx(x_idx), .y_idx(y_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pc(pc), .busy(busy), .done(done), .err(err),
        .ea_ptr(ea_ptr), .ea_val(ea_val)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] mb(logic [15:0] a);
        return mem[a[11:0]];
    endfunction

    task automatic put(logic [15:0] a, logic [7:0] d);
        mem[a[11:0]] = d;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference built from the requirement text
    task automatic ref_op(int m, bit r, logic [7:0] x, logic [7:0] y, logic [15:0] p0,
                          output logic [15:0] ptr, output logic [7:0] val,
                          output logic [15:0] npc, output int nrd);
        logic [7:0] b;
        logic [15:0] w, a;
        b = mb(p0);
        w = {mb(p0 + 16'd1), b};
        ptr = '0; val = '0; npc = p0; nrd = 0;
        case (m)
            2, 3: begin ptr = {8'h00, b}; val = b; npc = p0 + 1; nrd = 1; end
            4, 5: begin
                npc = p0 + 1;
                if (r) begin ptr = {8'h00, b}; val = b; nrd = 1; end
                else begin ptr = {8'h00, b} + {8'h00, (m == 5) ? y : x}; val = mb(ptr); nrd = 2; end
            end
            6, 7, 8: begin
                npc = p0 + 2;
                if (r) begin ptr = w; val = w[7:0]; nrd = 2; end
                else begin
                    ptr = w + ((m == 7) ? {8'h00, x} : (m == 8) ? {8'h00, y} : 16'h0);
                    val = mb(ptr); nrd = 3;
                end
            end
            9: begin
                npc = p0 + 2;
                if (r) begin ptr = w; val = w[7:0]; nrd = 2; end
                else begin ptr = {mb(w + 16'd1), mb(w)}; val = mb(ptr); nrd = 5; end
            end
            10, 11: begin
                npc = p0 + 1;
                if (r) begin ptr = {8'h00, b}; val = b; nrd = 1; end
                else begin
                    a = {8'h00, b} + ((m == 10) ? {8'h00, x} : 16'h0);
                    ptr = {mb(a + 16'd1), mb(a)} + ((m == 11) ? {8'h00, y} : 16'h0);
                    val = mb(ptr); nrd = 4;
                end
            end
            12: begin
                npc = p0 + 1;
                ptr = p0 + 16'd1 + {{8{b[7]}}, b};
                if (r) begin val = ptr[7:0]; nrd = 1; end
                else begin val = mb(ptr); nrd = 2; end
            end
            default: ;
        endcase
    endtask

    task automatic run_op(string req, int m, bit r, logic [7:0] x, logic [7:0] y);
        logic [15:0] e_ptr, e_npc;
        logic [7:0]  e_val;
        int e_nrd, nrd, waited;
        ref_op(m, r, x, y, exp_pc, e_ptr, e_val, e_npc, e_nrd);
        @(negedge clk);
        mode = 4'(m); raw = r; x_idx = x; y_idx = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nrd = 0; waited = 0;
        while (!done && waited < 30) begin
            if (mem_rd) nrd++;
            waited++;
            @(negedge clk);
        end
        chk(req, "done seen", 32'(done), 32'd1);
        chk(req, "pointer", 32'(ea_ptr), 32'(e_ptr));
        chk(req, "value", 32'(ea_val), 32'(e_val));
        chk(req, "pc", 32'(pc), 32'(e_npc));
        chk("R13", "read cycles", 32'(nrd), 32'(e_nrd));
        @(negedge clk);
        chk("R13", "done width", 32'(done), 32'd0);
        exp_pc = e_npc;
    endtask

    task automatic t_reset;
        chk("R1", "pc", 32'(pc), 32'h0600);
        chk("R1", "done/err/busy/rd", {28'd0, done, err, busy, mem_rd}, 32'd0);
    endtask

    task automatic t_invalid(int m);
        int ne, nd, nr;
        logic [15:0] p0;
        p0 = pc;
        @(negedge clk);
        mode = 4'(m); raw = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ne = 0; nd = 0; nr = 0;
        for (int i = 0; i < 4; i++) begin
            if (err) ne++;
            if (done) nd++;
            if (mem_rd) nr++;
            @(negedge clk);
        end
        chk("R12", "err cycles", 32'(ne), 32'd1);
        chk("R12", "done count", 32'(nd), 32'd0);
        chk("R12", "reads", 32'(nr), 32'd0);
        chk("R12", "pc", 32'(pc), 32'(p0));
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        run_op("R2", 0, 1'b0, 8'h11, 8'h22);
        run_op("R2", 1, 1'b0, 8'h11, 8'h22);

        put(exp_pc, 8'h9C);
        run_op("R3", 2, 1'b0, 8'h00, 8'h00);
        put(exp_pc, 8'h42);
        run_op("R3", 3, 1'b0, 8'h00, 8'h00);

        put(exp_pc, 8'h34); put(exp_pc + 1, 8'h12); put(16'h1234, 8'hA5);
        run_op("R4", 6, 1'b0, 8'h00, 8'h00);

        put(exp_pc, 8'h10);
        run_op("R5", 12, 1'b0, 8'h00, 8'h00);
        put(exp_pc, 8'hF0);
        run_op("R5", 12, 1'b0, 8'h00, 8'h00);

        put(exp_pc, 8'h80); put(exp_pc + 1, 8'h2F);
        put(16'h2F80, 8'h56); put(16'h2F81, 8'h34); put(16'h3456, 8'h77);
        run_op("R6", 9, 1'b0, 8'h00, 8'h00);

        put(exp_pc, 8'hF0); put(exp_pc + 1, 8'h12); put(16'h1310, 8'h3B);
        run_op("R7", 7, 1'b0, 8'h20, 8'h00);
        put(exp_pc, 8'hFF); put(exp_pc + 1, 8'h0F); put(16'h10FE, 8'h4E);
        run_op("R7", 8, 1'b0, 8'h00, 8'hFF);

        put(exp_pc, 8'hF8); put(16'h0108, 8'hC3);
        run_op("R8", 4, 1'b0, 8'h10, 8'h00);
        put(exp_pc, 8'h80); put(16'h0085, 8'h5D);
        run_op("R8", 5, 1'b0, 8'h00, 8'h05);

        put(exp_pc, 8'hFF); put(16'h0100, 8'hCD); put(16'h0101, 8'hAB); put(16'hABCD, 8'h61);
        run_op("R9", 10, 1'b0, 8'h01, 8'h00);

        put(exp_pc, 8'hFF); put(16'h00FF, 8'h10); put(16'hCD40, 8'h92);
        run_op("R10", 11, 1'b0, 8'h00, 8'h30);

        put(exp_pc, 8'hF0); put(exp_pc + 1, 8'h12);
        run_op("R11", 7, 1'b1, 8'h20, 8'h00);
        put(exp_pc, 8'h80); put(exp_pc + 1, 8'h2F);
        run_op("R11", 9, 1'b1, 8'h00, 8'h00);
        put(exp_pc, 8'hF8);
        run_op("R11", 4, 1'b1, 8'h10, 8'h00);
        put(exp_pc, 8'hFF);
        run_op("R11", 10, 1'b1, 8'h01, 8'h00);
        put(exp_pc, 8'hFF);
        run_op("R11", 11, 1'b1, 8'h00, 8'h30);
        put(exp_pc, 8'hF0);
        run_op("R11", 12, 1'b1, 8'h00, 8'h00);

        t_invalid(13);
        t_invalid(15);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule